// File: doc/BRIEF.md
# Segmented Coefficient Multiplier

This block forms one coefficient-times-sample product for an FIR datapath without using a full-width multiplier. The magnitude of every nonzero coefficient is stored in two parts. The first part is a power of two, kept only as its exponent. The second part is a positive remainder. The sample is shifted left by the exponent, a narrow multiplier scales the same sample by the remainder, and an adder joins the two partial results. A stored sign flag negates the sum, and a stored zero flag forces the result to zero.

Coefficient entries are prepared offline and arrive already split. For a magnitude that is not a power of two, the exponent names the largest power of two below the magnitude. For an exact power of two, the exponent is one lower and the remainder equals that lower power, so the remainder never becomes zero. The result is registered. A two-state controller raises the output-valid flag in the cycle after each accepted input. Its states are `ST_EMPTY`, where no fresh result is present, and `ST_FULL`, where a fresh result is present. Transition LOAD enters `ST_FULL` from either state when `in_valid` is high. Transition DRAIN enters `ST_EMPTY` from either state when `in_valid` is low.

Top module: `seg_coef_mul`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `product` is 0.
- R2: When `in_valid` is high at a rising clock edge, `out_valid` is 1 after that edge and `product` equals x·(2^e + m). Here x is `sample` read as two's complement, e is `coef_exp` read as unsigned, and m is `coef_rem` read as unsigned.
- R3: When `coef_neg` is 1 and `coef_zero` is 0, the registered product is −x·(2^e + m).
- R4: When `coef_zero` is 1, the registered product is 0, whatever the exponent, remainder, sign flag and sample are.
- R5: A power-of-two coefficient 2^k, stored as e = k−1 and m = 2^(k−1), yields exactly x·2^k.
- R6: When `in_valid` is low at a rising edge, `out_valid` is 0 after that edge and `product` keeps its previous value.
- R7: The extreme cases are exact in the 28-bit signed result: x = −2048 or 2047 with e = 15, m = 2047, and either sign.
- R8: The smallest exponent, e = 0 with m = 1 (a magnitude of 2), gives the exact product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The sample and coefficient fields are to be used at this edge |
| sample | input | 12 | Data sample, two's complement |
| coef_exp | input | 4 | Exponent of the power-of-two part |
| coef_rem | input | 11 | Positive remainder of the coefficient magnitude |
| coef_neg | input | 1 | Coefficient is negative |
| coef_zero | input | 1 | Coefficient is zero |
| out_valid | output | 1 | `product` holds a result computed from the previous accepted input |
| product | output | 28 | Registered signed product |

## Verification
The assertions treat the fields as a legal entry: the remainder lies between 1 and 2^e inclusive, and the flags are ignored except when they are meant. The exact-product check is nevertheless written so that it holds for any field values, because every value that fits the field widths fits 28 bits. The stimulus table holds only decompositions obeying that rule. It includes the power-of-two encoding, the smallest exponent and the largest magnitudes. Zero-flag rows carry nonzero garbage in the other fields on purpose, so that the forcing is visible at the output. Inputs change only away from the active edge. Reset is applied during idle cycles and once after activity.

// File: rtl/scm_pkg.sv
package scm_pkg;

    localparam int SCM_DATA_W = 12;
    localparam int SCM_EXP_W  = 4;
    localparam int SCM_REM_W  = 11;
    localparam int SCM_PROD_W = 28;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } scm_state_e;

endpackage

// File: rtl/scm_shift_path.sv
// Power-of-two branch: logarithmic left shifter on the sign-extended sample.
module scm_shift_path #(
    parameter int DATA_W = 12,
    parameter int EXP_W  = 4,
    parameter int PROD_W = 28
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [EXP_W-1:0]  shamt,
    output logic [PROD_W-1:0] shifted
);
    localparam int EXT_W = PROD_W - DATA_W;

    logic [PROD_W-1:0] stage [0:EXP_W];

    assign stage[0] = {{EXT_W{sample[DATA_W-1]}}, sample};

    genvar gi;
    generate
        for (gi = 0; gi < EXP_W; gi++) begin : g_stage
            assign stage[gi+1] = shamt[gi] ? (stage[gi] << (1 << gi)) : stage[gi];
        end
    endgenerate

    assign shifted = stage[EXP_W];

    // R2: the bits below the shift amount must be cleared
    always_comb begin
        low_bits_clear_chk : assert (((shifted & ((PROD_W'(1) << shamt) - PROD_W'(1))) == '0) || $isunknown(shamt));
    end
endmodule

// File: rtl/scm_rem_mult.sv
// Remainder branch: narrow signed-by-unsigned multiply.
module scm_rem_mult #(
    parameter int DATA_W = 12,
    parameter int REM_W  = 11
) (
    input  logic [DATA_W-1:0]        sample,
    input  logic [REM_W-1:0]         rem,
    output logic [DATA_W+REM_W:0]    partial
);
    localparam int MUL_W = DATA_W + REM_W + 1;

    logic [MUL_W-1:0] sx;
    logic [MUL_W-1:0] mx;

    assign sx      = {{(MUL_W-DATA_W){sample[DATA_W-1]}}, sample};
    assign mx      = {{(MUL_W-REM_W){1'b0}}, rem};
    assign partial = sx * mx;
endmodule

// File: rtl/scm_sum_sign.sv
// Joins both branches, then applies the sign and zero flags.
module scm_sum_sign #(
    parameter int MUL_W  = 24,
    parameter int PROD_W = 28
) (
    input  logic [PROD_W-1:0] shifted,
    input  logic [MUL_W-1:0]  partial,
    input  logic              neg,
    input  logic              zero,
    output logic [PROD_W-1:0] result
);
    logic [PROD_W-1:0] magnitude_sum;

    always_comb begin
        magnitude_sum = shifted + {{(PROD_W-MUL_W){partial[MUL_W-1]}}, partial};
        if (zero) begin
            result = '0;
        end else if (neg) begin
            result = '0 - magnitude_sum;
        end else begin
            result = magnitude_sum;
        end
    end
endmodule

// File: rtl/seg_coef_mul.sv
module seg_coef_mul
    import scm_pkg::*;
#(
    parameter int DATA_W = SCM_DATA_W,
    parameter int EXP_W  = SCM_EXP_W,
    parameter int REM_W  = SCM_REM_W,
    parameter int PROD_W = SCM_PROD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] sample,
    input  logic [EXP_W-1:0]  coef_exp,
    input  logic [REM_W-1:0]  coef_rem,
    input  logic              coef_neg,
    input  logic              coef_zero,
    output logic              out_valid,
    output logic [PROD_W-1:0] product
);
    localparam int MUL_W = DATA_W + REM_W + 1;
    localparam int MAG_W = (1 << EXP_W) + 1;

    scm_state_e        state_q;
    scm_state_e        state_d;
    logic [PROD_W-1:0] shifted;
    logic [MUL_W-1:0]  partial;
    logic [PROD_W-1:0] result;

    scm_shift_path #(.DATA_W(DATA_W), .EXP_W(EXP_W), .PROD_W(PROD_W)) u_shift (
        .sample  (sample),
        .shamt   (coef_exp),
        .shifted (shifted)
    );

    scm_rem_mult #(.DATA_W(DATA_W), .REM_W(REM_W)) u_mult (
        .sample  (sample),
        .rem     (coef_rem),
        .partial (partial)
    );

    scm_sum_sign #(.MUL_W(MUL_W), .PROD_W(PROD_W)) u_sum (
        .shifted (shifted),
        .partial (partial),
        .neg     (coef_neg),
        .zero    (coef_zero),
        .result  (result)
    );

    // Next-state selection: LOAD and DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output process: result register and valid flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            product <= '0;
        end else if (in_valid) begin
            product <= result;
        end
    end

    assign out_valid = (state_q == ST_FULL);

    // Reference model for the checks: a single full-width multiply by the whole magnitude.
    logic [MAG_W-1:0]  chk_mag;
    logic [PROD_W-1:0] chk_sx;
    logic [PROD_W-1:0] chk_full;
    logic [PROD_W-1:0] chk_ref;

    always_comb begin
        chk_mag  = (MAG_W'(1) << coef_exp) + MAG_W'(coef_rem);
        chk_sx   = {{(PROD_W-DATA_W){sample[DATA_W-1]}}, sample};
        chk_full = chk_sx * {{(PROD_W-MAG_W){1'b0}}, chk_mag};
        chk_ref  = coef_zero ? '0 : (coef_neg ? ('0 - chk_full) : chk_full);
    end

    // R2
    exact_product_chk : assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && product == $past(chk_ref)));

    // R3
    sign_rule_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !coef_zero && sample != '0) |=>
            (product[PROD_W-1] == ($past(sample[DATA_W-1]) ^ $past(coef_neg))));

    // R4
    zero_force_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && coef_zero) |=> (product == '0));

    // R6
    hold_idle_chk : assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(product)));
endmodule

// File: tb/seg_coef_mul_test.sv
module seg_coef_mul_test;
    localparam int NV = 12;

    // Row layout, high bits to low: req(4) neg(1) zero(1) exp(4) rem(11) sample(12)
    localparam logic [32:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 4'd3,  11'd5,    12'd100},
        {4'd2, 1'b0, 1'b0, 4'd6,  11'd20,   12'hED4},
        {4'd3, 1'b1, 1'b0, 4'd4,  11'd9,    12'd77},
        {4'd3, 1'b1, 1'b0, 4'd10, 11'd1000, 12'hFFF},
        {4'd4, 1'b1, 1'b1, 4'd9,  11'd300,  12'd55},
        {4'd4, 1'b0, 1'b1, 4'd15, 11'd2047, 12'h800},
        {4'd5, 1'b0, 1'b0, 4'd5,  11'd32,   12'd123},
        {4'd8, 1'b0, 1'b0, 4'd0,  11'd1,    12'hFFB},
        {4'd7, 1'b1, 1'b0, 4'd15, 11'd2047, 12'h800},
        {4'd7, 1'b0, 1'b0, 4'd15, 11'd2047, 12'h7FF},
        {4'd2, 1'b0, 1'b0, 4'd7,  11'd100,  12'd0},
        {4'd5, 1'b1, 1'b0, 4'd10, 11'd1024, 12'h3E8}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] sample = '0;
    logic [3:0]  coef_exp = '0;
    logic [10:0] coef_rem = '0;
    logic        coef_neg = 1'b0;
    logic        coef_zero = 1'b0;
    logic        out_valid;
    logic [27:0] product;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    seg_coef_mul uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample(sample),
        .coef_exp(coef_exp), .coef_rem(coef_rem), .coef_neg(coef_neg),
        .coef_zero(coef_zero), .out_valid(out_valid), .product(product)
    );

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    function automatic longint expect_of(input logic [32:0] v);
        longint x;
        longint h;
        longint p;
        x = longint'($signed(v[11:0]));
        h = (longint'(1) << v[26:23]) + longint'(v[22:12]);
        p = x * h;
        if (v[27]) p = 0;
        else if (v[28]) p = -p;
        return p;
    endfunction

    task automatic check(input string t, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic drive(input logic [32:0] v);
        sample    = v[11:0];
        coef_rem  = v[22:12];
        coef_exp  = v[26:23];
        coef_zero = v[27];
        coef_neg  = v[28];
        in_valid  = 1'b1;
    endtask

    initial begin
        longint last;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", longint'(out_valid), 0);
        check("R1", longint'(product), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", longint'(out_valid), 0);

        // Table walk, back to back: drive one row, check the previous row
        drive(VEC[0]);
        for (int i = 1; i <= NV; i++) begin
            @(negedge clk);
            check(tag(VEC[i-1][32:29]), longint'($signed(product)), expect_of(VEC[i-1]));
            check("R2", longint'(out_valid), 1);
            if (i < NV) drive(VEC[i]);
        end
        last = longint'($signed(product));

        // R6: idle with other fields changed
        in_valid = 1'b0;
        sample = 12'd999; coef_exp = 4'd2; coef_rem = 11'd3; coef_neg = 1'b1; coef_zero = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R6", longint'(out_valid), 0);
            check("R6", longint'($signed(product)), last);
        end

        // R4: zero flag with a nonzero pending value in the register
        drive({4'd4, 1'b0, 1'b0, 4'd2, 11'd3, 12'd10});
        @(negedge clk);
        check("R2", longint'($signed(product)), 70);
        drive({4'd4, 1'b0, 1'b1, 4'd12, 11'd777, 12'h9AB});
        @(negedge clk);
        check("R4", longint'(product), 0);

        // R1: reset after activity
        drive({4'd2, 1'b0, 1'b0, 4'd1, 11'd1, 12'd4});
        @(negedge clk);
        check("R2", longint'($signed(product)), 12);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1", longint'(product), 0);
        check("R1", longint'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", longint'(product), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL all: watchdog expired, actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule